// File: doc/BRIEF.md
# Repair Guard Key Detector

This block sits on the device side of a memory command path and watches an already decoded command stream. It decides whether hard row-repair mode has truly been unlocked. Unlocking takes two steps. First a mode-register-4 write must set address bit 13. Then four guard-key writes to mode register 0 must arrive back to back and in the exact order. Once unlocked, an activate names the failing row, and a following write or write with auto-precharge to the same bank fires a one-cycle repair trigger. The trigger carries the captured bank group, bank and row to the fuse logic, which is outside this block.

A broken or out-of-order key sequence never arms the block. The key writes then behave as no-ops, and a later activate and write are plain accesses. A one-cycle pulse reports each abandoned partial sequence.

The state machine has eight named states:
- `ST_IDLE`: repair not enabled.
- `ST_ENABLED`: bit 13 set, no key yet.
- `ST_KEY1`, `ST_KEY2`, `ST_KEY3`: that many keys accepted.
- `ST_ARMED`: all four keys accepted.
- `ST_ROW_OPEN`: repair row captured.
- `ST_SPENT`: trigger issued.

Its transitions are:
- enable: `ST_IDLE`→`ST_ENABLED` on a mode-register-4 write with bit 13 = 1.
- advance: `ST_ENABLED`→`ST_KEY1`→`ST_KEY2`→`ST_KEY3`→`ST_ARMED`, each on the expected key.
- abandon: `ST_KEY1..3`→`ST_ENABLED` on any other valid command, with the drop pulse.
- capture: `ST_ARMED`→`ST_ROW_OPEN` on an activate.
- recapture: `ST_ROW_OPEN`→`ST_ROW_OPEN` on another activate.
- fire: `ST_ROW_OPEN`→`ST_SPENT` on a write to the captured bank.
- disable: any state→`ST_IDLE` on a mode-register-4 write with bit 13 = 0.

Top module: `repair_unlock_mon`

## Requirements
- R1: After reset, and after any reset asserted mid-run, `armed`, `repair_fire` and `seq_drop` are 0.
- R2: Guard keys are ignored until a mode-register-4 write is seen. Such a write has opcode MRS = 4'd1, `cmd_bg` = 2'b01, `cmd_ba` = 2'b00 and `cmd_addr[13]` = 1.
- R3: A guard key is an MRS with `cmd_bg` = 0 and `cmd_ba` = 0. Four consecutive valid keys whose `cmd_addr[11:7]` equal 11001, 01111, 10111 and 00111, in that order, make `armed` read 1 in the cycle after the fourth key. `cmd_addr[17:12]` is ignored.
- R4: With `cfg_low_dc` = 0, a key also needs `cmd_addr[6:0]` = 7'h7F. With `cfg_low_dc` = 1, those bits are ignored.
- R5: Any valid command other than the next expected key returns the sequence to no keys, and `armed` stays 0. This covers an out-of-order key and any activate, write, read, precharge, refresh, ZQ (4'd8), no-op (4'd0) or other mode-register write.
- R6: `seq_drop` pulses for exactly one cycle when a sequence holding one to three accepted keys is abandoned. This includes abandonment by a repair-disable write.
- R7: While armed, an activate (opcode 4'd2) captures bank group, bank and row, and a later activate recaptures them. A write (4'd3) or write with auto-precharge (4'd4) to the captured bank group and bank then raises `repair_fire` for one cycle, with the captured values on `fire_bg`, `fire_ba` and `fire_row`. `armed` then falls.
- R8: While armed, a write to a bank other than the captured one does not fire.
- R9: Activate and write issued while not armed never fire.
- R10: Refresh (opcode 4'd7) while armed keeps the block armed and keeps the captured row.
- R11: A mode-register-4 write with `cmd_addr[13]` = 0 returns the block to idle from any state. Keys then need a new enable.
- R12: Cycles with `cmd_vld` = 0 are not commands: they neither advance nor interrupt the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Opcode: 0 NOP, 1 MRS, 2 ACT, 3 WR, 4 WRA, 5 RD, 6 PRE, 7 REF, 8 ZQ |
| cmd_bg | input | 2 | Bank group (MRS: bit 0 is mode-register select bit 2) |
| cmd_ba | input | 2 | Bank (MRS: mode-register select bits 1:0) |
| cmd_addr | input | 18 | Address / row / mode-register operand |
| cfg_low_dc | input | 1 | 1: key bits 6:0 are don't care |
| armed | output | 1 | Repair unlocked and waiting for, or holding, a row |
| repair_fire | output | 1 | One-cycle repair trigger |
| fire_bg | output | 2 | Captured bank group |
| fire_ba | output | 2 | Captured bank |
| fire_row | output | 18 | Captured row |
| seq_drop | output | 1 | One-cycle pulse: partial key sequence abandoned |

## Verification
A clean enable followed by four in-order keys is the baseline. It is contrasted with the same keys sent before any enable, which separates gating from key matching. An out-of-order key and a no-op wedged between keys each show abandonment and its pulse. A key with zeroed low bits, tried under both settings of the don't-care input, shows that the low field is checked or ignored as configured. Idle cycles between keys show that empty slots do not interrupt. While armed, a refresh, a write to the wrong bank, a recapturing activate and a matching write separate tolerated commands from the real trigger, and the check of the reported row shows that the last activate wins.

// File: rtl/repair_unlock_pkg.sv
package repair_unlock_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_MRS = 4'd1,
        OP_ACT = 4'd2,
        OP_WR  = 4'd3,
        OP_WRA = 4'd4,
        OP_RD  = 4'd5,
        OP_PRE = 4'd6,
        OP_REF = 4'd7,
        OP_ZQ  = 4'd8
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLED,
        ST_KEY1,
        ST_KEY2,
        ST_KEY3,
        ST_ARMED,
        ST_ROW_OPEN,
        ST_SPENT
    } seq_state_e;

    localparam int KEY_COUNT = 4;
    localparam int KEY_W     = 5;

    // Order is behaviour: key n must match entry n.
    localparam logic [KEY_W-1:0] GUARD_PATTERN [KEY_COUNT] = '{
        5'b11001, 5'b01111, 5'b10111, 5'b00111
    };

endpackage

// File: rtl/repair_cmd_decode.sv
module repair_cmd_decode
    import repair_unlock_pkg::*;
#(
    parameter int BG_W = 2,
    parameter int BA_W = 2
) (
    input  logic            cmd_vld,
    input  logic [3:0]      cmd_op,
    input  logic [BG_W-1:0] cmd_bg,
    input  logic [BA_W-1:0] cmd_ba,
    output logic            is_mr0,
    output logic            is_mr4,
    output logic            is_act,
    output logic            is_write
);
    localparam logic [BG_W-1:0] MR4_BG = BG_W'(1);

    logic is_mrs;

    always_comb begin
        is_mrs   = cmd_vld && (cmd_op == OP_MRS);
        is_mr0   = is_mrs && (cmd_bg == '0) && (cmd_ba == '0);
        is_mr4   = is_mrs && (cmd_bg == MR4_BG) && (cmd_ba == '0);
        is_act   = cmd_vld && (cmd_op == OP_ACT);
        is_write = cmd_vld && ((cmd_op == OP_WR) || (cmd_op == OP_WRA));
    end

endmodule

// File: rtl/repair_key_cmp.sv
module repair_key_cmp
    import repair_unlock_pkg::*;
#(
    parameter int LOW_W = 7
) (
    input  logic                 is_mr0,
    input  logic [KEY_W-1:0]     key_field,
    input  logic [LOW_W-1:0]     low_field,
    input  logic                 low_dc,
    output logic [KEY_COUNT-1:0] key_hit
);
    logic low_ok;

    assign low_ok = low_dc || (low_field == {LOW_W{1'b1}});

    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
        assign key_hit[k] = is_mr0 && low_ok && (key_field == GUARD_PATTERN[k]);
    end

endmodule

// File: rtl/repair_row_latch.sv
module repair_row_latch #(
    parameter int BG_W  = 2,
    parameter int BA_W  = 2,
    parameter int ROW_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [BG_W-1:0]  cmd_bg,
    input  logic [BA_W-1:0]  cmd_ba,
    input  logic [ROW_W-1:0] cmd_row,
    output logic [BG_W-1:0]  held_bg,
    output logic [BA_W-1:0]  held_ba,
    output logic [ROW_W-1:0] held_row,
    output logic             bank_match
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_bg  <= '0;
            held_ba  <= '0;
            held_row <= '0;
        end else if (capture) begin
            held_bg  <= cmd_bg;
            held_ba  <= cmd_ba;
            held_row <= cmd_row;
        end
    end

    assign bank_match = (cmd_bg == held_bg) && (cmd_ba == held_ba);

    // R7
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (held_row == $past(cmd_row)) && (held_bg == $past(cmd_bg)));

endmodule

// File: rtl/repair_seq_fsm.sv
module repair_seq_fsm
    import repair_unlock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic                 is_mr4,
    input  logic                 mr4_bit,
    input  logic                 is_act,
    input  logic                 is_write,
    input  logic [KEY_COUNT-1:0] key_hit,
    input  logic                 bank_match,
    output logic                 capture,
    output logic                 armed,
    output logic                 fire_q,
    output logic                 drop_q
);
    seq_state_e st, st_nxt;
    logic       fire_nxt, drop_nxt, partial;

    assign partial = (st == ST_KEY1) || (st == ST_KEY2) || (st == ST_KEY3);

    always_comb begin
        st_nxt   = st;
        fire_nxt = 1'b0;
        drop_nxt = 1'b0;
        capture  = 1'b0;
        if (cmd_vld) begin
            if (is_mr4 && !mr4_bit) begin
                st_nxt   = ST_IDLE;
                drop_nxt = partial;
            end else begin
                unique case (st)
                    ST_IDLE:    if (is_mr4) st_nxt = ST_ENABLED;
                    ST_ENABLED: if (key_hit[0]) st_nxt = ST_KEY1;
                    ST_KEY1: begin
                        if (key_hit[1]) st_nxt = ST_KEY2;
                        else begin st_nxt = ST_ENABLED; drop_nxt = 1'b1; end
                    end
                    ST_KEY2: begin
                        if (key_hit[2]) st_nxt = ST_KEY3;
                        else begin st_nxt = ST_ENABLED; drop_nxt = 1'b1; end
                    end
                    ST_KEY3: begin
                        if (key_hit[3]) st_nxt = ST_ARMED;
                        else begin st_nxt = ST_ENABLED; drop_nxt = 1'b1; end
                    end
                    ST_ARMED: begin
                        if (is_act) begin st_nxt = ST_ROW_OPEN; capture = 1'b1; end
                    end
                    ST_ROW_OPEN: begin
                        if (is_act) capture = 1'b1;
                        else if (is_write && bank_match) begin
                            st_nxt   = ST_SPENT;
                            fire_nxt = 1'b1;
                        end
                    end
                    ST_SPENT: st_nxt = ST_SPENT;
                    default:  st_nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            fire_q <= fire_nxt;
            drop_q <= drop_nxt;
        end
    end

    assign armed = (st == ST_ARMED) || (st == ST_ROW_OPEN);

    // R3
    arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(cmd_vld && key_hit[3]));

    // R7
    fire_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> ($past(st) == ST_ROW_OPEN) && !armed);

    // R6
    drop_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> (($past(st) == ST_KEY1) || ($past(st) == ST_KEY2)
                    || ($past(st) == ST_KEY3)) && !armed);

    // R11
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && is_mr4 && !mr4_bit) |=> (st == ST_IDLE) && !armed);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> $stable(st) && !fire_q && !drop_q);

endmodule

// File: rtl/repair_unlock_mon.sv
module repair_unlock_mon
    import repair_unlock_pkg::*;
#(
    parameter int BG_W    = 2,
    parameter int BA_W    = 2,
    parameter int ROW_W   = 18,
    parameter int KEY_LSB = 7,
    parameter int EN_BIT  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [3:0]       cmd_op,
    input  logic [BG_W-1:0]  cmd_bg,
    input  logic [BA_W-1:0]  cmd_ba,
    input  logic [ROW_W-1:0] cmd_addr,
    input  logic             cfg_low_dc,
    output logic             armed,
    output logic             repair_fire,
    output logic [BG_W-1:0]  fire_bg,
    output logic [BA_W-1:0]  fire_ba,
    output logic [ROW_W-1:0] fire_row,
    output logic             seq_drop
);
    localparam int LOW_W   = KEY_LSB;
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    logic                 is_mr0, is_mr4, is_act, is_write;
    logic [KEY_COUNT-1:0] key_hit;
    logic                 capture, bank_match;

    repair_cmd_decode #(.BG_W(BG_W), .BA_W(BA_W)) u_dec (
        .cmd_vld  (cmd_vld),
        .cmd_op   (cmd_op),
        .cmd_bg   (cmd_bg),
        .cmd_ba   (cmd_ba),
        .is_mr0   (is_mr0),
        .is_mr4   (is_mr4),
        .is_act   (is_act),
        .is_write (is_write)
    );

    repair_key_cmp #(.LOW_W(LOW_W)) u_keys (
        .is_mr0    (is_mr0),
        .key_field (cmd_addr[KEY_MSB:KEY_LSB]),
        .low_field (cmd_addr[LOW_W-1:0]),
        .low_dc    (cfg_low_dc),
        .key_hit   (key_hit)
    );

    repair_row_latch #(.BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cmd_bg     (cmd_bg),
        .cmd_ba     (cmd_ba),
        .cmd_row    (cmd_addr),
        .held_bg    (fire_bg),
        .held_ba    (fire_ba),
        .held_row   (fire_row),
        .bank_match (bank_match)
    );

    repair_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_vld    (cmd_vld),
        .is_mr4     (is_mr4),
        .mr4_bit    (cmd_addr[EN_BIT]),
        .is_act     (is_act),
        .is_write   (is_write),
        .key_hit    (key_hit),
        .bank_match (bank_match),
        .capture    (capture),
        .armed      (armed),
        .fire_q     (repair_fire),
        .drop_q     (seq_drop)
    );

endmodule

// File: tb/repair_unlock_mon_tb_top.sv
`timescale 1ns/100ps
module repair_unlock_mon_tb_top;

    typedef struct packed {
        logic        vld;
        logic [3:0]  op;
        logic [1:0]  bg;
        logic [1:0]  ba;
        logic [17:0] addr;
        logic        lowdc;
        logic        e_armed;
        logic        e_fire;
        logic        e_drop;
        logic [3:0]  req;
    } vec_t;

    localparam logic [17:0] K1 = 18'h00CFF, K2 = 18'h007FF, K3 = 18'h00BFF, K4 = 18'h003FF;
    localparam logic [17:0] K1L = 18'h00C80, K2L = 18'h00780, K3L = 18'h00B80, K4L = 18'h00380;
    localparam logic [17:0] EN = 18'h02000;
    localparam int NV = 40;

    localparam vec_t TBL [NV] = '{
        '{1'b1, 4'd1, 2'd0, 2'd0, K1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 keys before enable
        '{1'b1, 4'd1, 2'd0, 2'd0, K2,  1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd1, 2'd0, 2'd0, K3,  1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd1, 2'd0, 2'd0, K4,  1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd1, 2'd1, 2'd0, EN,  1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd1, 2'd0, 2'd0, K1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 4'd1, 2'd0, 2'd0, K2,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 4'd0, 2'd0, 2'd0, 18'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 NOP between keys
        '{1'b1, 4'd1, 2'd0, 2'd0, K1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 4'd1, 2'd0, 2'd0, K2,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 4'd1, 2'd0, 2'd0, K3,  1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 4'd1, 2'd0, 2'd0, K4,  1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 armed
        '{1'b0, 4'd0, 2'd0, 2'd0, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd12},
        '{1'b1, 4'd7, 2'd0, 2'd0, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
        '{1'b1, 4'd2, 2'd2, 2'd1, 18'h01234, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 4'd3, 2'd2, 2'd0, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{1'b1, 4'd7, 2'd0, 2'd0, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10},
        '{1'b1, 4'd4, 2'd2, 2'd1, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 fire
        '{1'b1, 4'd1, 2'd1, 2'd0, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 4'd1, 2'd1, 2'd0, EN,  1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 4'd1, 2'd0, 2'd0, K1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b1, 4'd1, 2'd0, 2'd0, K3,  1'b0, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 out of order
        '{1'b1, 4'd1, 2'd0, 2'd0, K1L, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 low bits checked
        '{1'b1, 4'd1, 2'd0, 2'd0, K2,  1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 4'd1, 2'd0, 2'd0, K3,  1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 4'd1, 2'd0, 2'd0, K4,  1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 4'd2, 2'd1, 2'd1, 18'h00055, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd3, 2'd1, 2'd1, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 4'd1, 2'd0, 2'd0, K1L, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 don't care
        '{1'b0, 4'd0, 2'd0, 2'd0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd12},
        '{1'b1, 4'd1, 2'd0, 2'd0, K2L, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b0, 4'd0, 2'd0, 2'd0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd12},
        '{1'b1, 4'd1, 2'd0, 2'd0, K3L, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 4'd1, 2'd0, 2'd0, K4L, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R12 gaps
        '{1'b1, 4'd5, 2'd0, 2'd0, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 4'd1, 2'd1, 2'd0, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 disable
        '{1'b1, 4'd1, 2'd0, 2'd0, K1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 4'd1, 2'd0, 2'd0, K2,  1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 4'd1, 2'd0, 2'd0, K3,  1'b0, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 4'd1, 2'd0, 2'd0, K4,  1'b0, 1'b0, 1'b0, 1'b0, 4'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_bg = '0;
    logic [1:0]  cmd_ba = '0;
    logic [17:0] cmd_addr = '0;
    logic        cfg_low_dc = 1'b0;
    logic        armed, repair_fire, seq_drop;
    logic [1:0]  fire_bg, fire_ba;
    logic [17:0] fire_row;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    repair_unlock_mon dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
        .cfg_low_dc(cfg_low_dc), .armed(armed), .repair_fire(repair_fire),
        .fire_bg(fire_bg), .fire_ba(fire_ba), .fire_row(fire_row),
        .seq_drop(seq_drop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] op, input logic [1:0] bg,
                         input logic [1:0] ba, input logic [17:0] a, input logic dc);
        @(negedge clk);
        cmd_vld = v; cmd_op = op; cmd_bg = bg; cmd_ba = ba; cmd_addr = a; cfg_low_dc = dc;
        @(posedge clk);
        #1;
    endtask

    task automatic arm_seq();
        drive(1'b1, 4'd1, 2'd1, 2'd0, EN, 1'b0);
        drive(1'b1, 4'd1, 2'd0, 2'd0, K1, 1'b0);
        drive(1'b1, 4'd1, 2'd0, 2'd0, K2, 1'b0);
        drive(1'b1, 4'd1, 2'd0, 2'd0, K3, 1'b0);
        drive(1'b1, 4'd1, 2'd0, 2'd0, K4, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 armed", {31'd0, armed}, 32'd0);
        check("R1 fire", {31'd0, repair_fire}, 32'd0);
        check("R1 drop", {31'd0, seq_drop}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(TBL[i].vld, TBL[i].op, TBL[i].bg, TBL[i].ba, TBL[i].addr, TBL[i].lowdc);
            tag = $sformatf("R%0d row %0d", TBL[i].req, i);
            check({tag, " armed"}, {31'd0, armed}, {31'd0, TBL[i].e_armed});
            check({tag, " fire"}, {31'd0, repair_fire}, {31'd0, TBL[i].e_fire});
            check({tag, " drop"}, {31'd0, seq_drop}, {31'd0, TBL[i].e_drop});
        end

        // R6: disable write abandons two keys -> one-cycle drop pulse
        drive(1'b1, 4'd1, 2'd1, 2'd0, EN, 1'b0);
        drive(1'b1, 4'd1, 2'd0, 2'd0, K1, 1'b0);
        drive(1'b1, 4'd1, 2'd0, 2'd0, K2, 1'b0);
        drive(1'b1, 4'd1, 2'd1, 2'd0, 18'h0, 1'b0);
        check("R6 drop on disable", {31'd0, seq_drop}, 32'd1);
        drive(1'b0, 4'd0, 2'd0, 2'd0, 18'h0, 1'b0);
        check("R6 drop one cycle", {31'd0, seq_drop}, 32'd0);

        // R7 recapture, R8 old bank ignored, captured values reported
        arm_seq();
        check("R3 armed directed", {31'd0, armed}, 32'd1);
        drive(1'b1, 4'd2, 2'd3, 2'd2, 18'h2ABCD, 1'b0);
        drive(1'b1, 4'd2, 2'd0, 2'd3, 18'h00011, 1'b0);
        drive(1'b1, 4'd3, 2'd3, 2'd2, 18'h0, 1'b0);
        check("R8 stale bank no fire", {31'd0, repair_fire}, 32'd0);
        drive(1'b1, 4'd3, 2'd0, 2'd3, 18'h0, 1'b0);
        check("R7 fire", {31'd0, repair_fire}, 32'd1);
        check("R7 fire_bg", {30'd0, fire_bg}, 32'd0);
        check("R7 fire_ba", {30'd0, fire_ba}, 32'd3);
        check("R7 fire_row", {14'd0, fire_row}, 32'h11);
        check("R7 disarmed", {31'd0, armed}, 32'd0);
        drive(1'b0, 4'd0, 2'd0, 2'd0, 18'h0, 1'b0);
        check("R7 fire one cycle", {31'd0, repair_fire}, 32'd0);

        // R1 reset while armed
        drive(1'b1, 4'd1, 2'd1, 2'd0, 18'h0, 1'b0);
        arm_seq();
        check("R1 pre-reset armed", {31'd0, armed}, 32'd1);
        @(negedge clk);
        cmd_vld = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset clears armed", {31'd0, armed}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule